// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This peripheral holds four independent timer channels behind one single-cycle register port. Each channel owns a counter, a reload register, a mode bit, an enable bit, an interrupt mask and a pending flag. The channels share one read-only status word that gathers the pending flags of all channels. When a channel is enabled, its counter steps down by one every clock. When it reaches zero, the channel raises its pending flag. In repeating mode the counter then refills from the reload register. In one-shot mode it parks at zero.

Software acknowledges an interrupt through a clear register that uses a short handshake. A clear request keeps a busy indication raised for a fixed number of cycles, and the pending flag drops only when that period ends. While busy is raised, further clear requests are discarded. Software can also restart a channel at any moment by writing anything to the restart register, which copies the reload value into the counter. The intended use is a periodic tick in repeating mode or a programmed deadline in one-shot mode. The block has one interrupt line per channel.

Top module: `quad_downtimer`

## Requirements
- R1: After the synchronous reset, every channel reads mode 0, reload 0, enable 0, count 0, pending 0 and busy 0. The mask bit reads 1, all interrupt outputs are 0 and the status word is 0.
- R2: Channel n's registers sit at n×0x40. Within a bank, 0x04 bit 0 is the mode (0 = repeating, 1 = one-shot), 0x08 is the 32-bit reload value, 0x10 bit 0 is enable, 0x24 bit 0 is the mask (1 = masked), and 0x18 returns the count. All of these read back what was written.
- R3: A write of 1 to enable while the channel is disabled copies the reload value into the counter at that edge. While enabled, a nonzero count falls by one per clock.
- R4: In repeating mode, an enabled counter at zero refills from the reload value on the next clock, so the count repeats with period reload+1.
- R5: In one-shot mode, an enabled counter at zero stays at zero.
- R6: The clock edge at which an enabled count moves from 1 to 0 sets the pending flag, which reads at bit 0 of offset 0x20.
- R7: Any write to offset 0x14, whatever its data, loads the reload value into the counter at that edge.
- R8: With enable at 0, the count is frozen and the pending flag is never set.
- R9: Writing 1 to bit 0 of 0x20 while busy (bit 1 of 0x20) is 0 raises busy for exactly 4 clock cycles, after which busy and pending both read 0. Writing 0 to bit 0 changes nothing.
- R10: Clear writes made while busy is 1 are ignored and do not lengthen the busy period.
- R11: If an expiry occurs on the same edge that ends a clear, the pending flag stays set.
- R12: Each interrupt output equals its channel's pending flag when that channel's mask is 0, and is 0 when the mask is 1.
- R13: Offset 0x00 of bank 0 returns the pending flags, with bit n for channel n. Offset 0x00 of any other bank returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 8 | Byte address: bank in bits 7:6, register in bits 5:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 4 | Per-channel interrupt, pending and not masked |

## Verification
The hardest case to reach is an expiry that lands on the very edge at which a clear handshake completes, because the busy window and the count must line up to the cycle. The bench reaches it by arithmetic. It enables a repeating channel with reload 5 and issues the clear on the following edge, so that the fourth busy cycle ends exactly when the count passes from 1 to 0. It then checks that the pending flag survives. Counting, refilling and first expiry are swept over every channel, both modes and several reload values. Each sampled count is compared with a closed-form expression.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  // bits of the address that select a register inside one channel bank
  localparam int BANK_BITS = 6;

  // register offsets inside a bank; software depends on these positions
  localparam logic [BANK_BITS-1:0] OFS_STATUS  = 6'h00;
  localparam logic [BANK_BITS-1:0] OFS_MODE    = 6'h04;
  localparam logic [BANK_BITS-1:0] OFS_RELOAD  = 6'h08;
  localparam logic [BANK_BITS-1:0] OFS_ENABLE  = 6'h10;
  localparam logic [BANK_BITS-1:0] OFS_RESTART = 6'h14;
  localparam logic [BANK_BITS-1:0] OFS_COUNT   = 6'h18;
  localparam logic [BANK_BITS-1:0] OFS_ACK     = 6'h20;
  localparam logic [BANK_BITS-1:0] OFS_MASK    = 6'h24;

  // layout of the acknowledge register on reads
  function automatic logic [1:0] ack_word(input logic pending, input logic busy);
    return {busy, pending};
  endfunction
endpackage

// File: rtl/qdt_channel.sv
module qdt_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_mode,
  input  logic             wr_reload,
  input  logic             wr_enable,
  input  logic             wr_restart,
  input  logic [CNT_W-1:0] wdata,
  output logic             single_o,
  output logic             enable_o,
  output logic [CNT_W-1:0] reload_val_o,
  output logic [CNT_W-1:0] count_o,
  output logic             refill_o,
  output logic             expire_o
);
  logic             single_q;
  logic             enable_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;

  // next count of a running channel
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic [CNT_W-1:0] rel,
                                            input logic one_shot);
    if (cur != '0) return cur - CNT_W'(1);
    return one_shot ? '0 : rel;
  endfunction

  // forced copy of the reload value: restart write or enable from off
  assign refill_o = wr_restart | (wr_enable & wdata[0] & ~enable_q);
  // count leaves 1 for 0 on this edge
  assign expire_o = enable_q & ~refill_o & (count_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      single_q <= 1'b0;
      enable_q <= 1'b0;
      reload_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_mode)   single_q <= wdata[0];
      if (wr_reload) reload_q <= wdata;
      if (wr_enable) enable_q <= wdata[0];
      if (refill_o)      count_q <= reload_q;
      else if (enable_q) count_q <= step(count_q, reload_q, single_q);
    end
  end

  assign single_o     = single_q;
  assign enable_o     = enable_q;
  assign reload_val_o = reload_q;
  assign count_o      = count_q;
endmodule

// File: rtl/qdt_ack.sv
module qdt_ack #(
  parameter int CLR_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic wr_ack,
  input  logic wr_mask,
  input  logic wbit,
  output logic pending_o,
  output logic busy_o,
  output logic done_o,
  output logic mask_o
);
  localparam int BW = $clog2(CLR_CYCLES + 1);

  logic [BW-1:0] left_q;
  logic          pending_q;
  logic          mask_q;
  logic          accept;

  assign busy_o = (left_q != '0);
  assign accept = wr_ack & wbit & ~busy_o;
  assign done_o = (left_q == BW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q    <= '0;
      pending_q <= 1'b0;
      mask_q    <= 1'b1;
    end else begin
      if (accept)      left_q <= BW'(CLR_CYCLES);
      else if (busy_o) left_q <= left_q - BW'(1);
      // a fresh expiry outranks the end of a clear
      if (expire)      pending_q <= 1'b1;
      else if (done_o) pending_q <= 1'b0;
      if (wr_mask) mask_q <= wbit;
    end
  end

  assign pending_o = pending_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/quad_downtimer.sv
module quad_downtimer
  import qdt_pkg::*;
#(
  parameter int NUM_CH     = 4,   // power of two
  parameter int CNT_W      = 32,
  parameter int DATA_W     = 32,
  parameter int CLR_CYCLES = 4,
  localparam int SEL_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W    = SEL_W + BANK_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq_o
);
  logic [SEL_W-1:0]     bank;
  logic [BANK_BITS-1:0] ofs;
  logic                 wr;

  // named internal events, also watched by the checker
  logic [NUM_CH-1:0]            ch_single, ch_enable, ch_refill, ch_expire;
  logic [NUM_CH-1:0]            ch_pend, ch_busy, ch_done, ch_mask;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_reload, ch_count;

  assign bank = bus_addr[ADDR_W-1:BANK_BITS];
  assign ofs  = bus_addr[BANK_BITS-1:0];
  assign wr   = bus_sel & bus_we;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr && (bank == SEL_W'(c));

    qdt_channel #(.CNT_W(CNT_W)) chan_i (
      .clk          (clk),
      .rst          (rst),
      .wr_mode      (hit && ofs == OFS_MODE),
      .wr_reload    (hit && ofs == OFS_RELOAD),
      .wr_enable    (hit && ofs == OFS_ENABLE),
      .wr_restart   (hit && ofs == OFS_RESTART),
      .wdata        (bus_wdata[CNT_W-1:0]),
      .single_o     (ch_single[c]),
      .enable_o     (ch_enable[c]),
      .reload_val_o (ch_reload[c]),
      .count_o      (ch_count[c]),
      .refill_o     (ch_refill[c]),
      .expire_o     (ch_expire[c])
    );

    qdt_ack #(.CLR_CYCLES(CLR_CYCLES)) ack_i (
      .clk       (clk),
      .rst       (rst),
      .expire    (ch_expire[c]),
      .wr_ack    (hit && ofs == OFS_ACK),
      .wr_mask   (hit && ofs == OFS_MASK),
      .wbit      (bus_wdata[0]),
      .pending_o (ch_pend[c]),
      .busy_o    (ch_busy[c]),
      .done_o    (ch_done[c]),
      .mask_o    (ch_mask[c])
    );

    assign irq_o[c] = ch_pend[c] & ~ch_mask[c];
  end

  always_comb begin
    bus_rdata = '0;
    case (ofs)
      OFS_STATUS: if (bank == '0) bus_rdata[NUM_CH-1:0] = ch_pend;
      OFS_MODE:   bus_rdata[0] = ch_single[bank];
      OFS_RELOAD: bus_rdata[CNT_W-1:0] = ch_reload[bank];
      OFS_ENABLE: bus_rdata[0] = ch_enable[bank];
      OFS_COUNT:  bus_rdata[CNT_W-1:0] = ch_count[bank];
      OFS_ACK:    bus_rdata[1:0] = ack_word(ch_pend[bank], ch_busy[bank]);
      OFS_MASK:   bus_rdata[0] = ch_mask[bank];
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qdt_checker.sv
module qdt_checker #(
  parameter int NUM_CH     = 4,
  parameter int CNT_W      = 32,
  parameter int CLR_CYCLES = 4
) (
  input logic                            clk,
  input logic                            rst,
  input logic [NUM_CH-1:0]               single,
  input logic [NUM_CH-1:0]               enable,
  input logic [NUM_CH-1:0]               refill,
  input logic [NUM_CH-1:0]               expire,
  input logic [NUM_CH-1:0]               pend,
  input logic [NUM_CH-1:0]               busy,
  input logic [NUM_CH-1:0]               done,
  input logic [NUM_CH-1:0][CNT_W-1:0]    count
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [15:0] busy_len;
    always_ff @(posedge clk) begin
      if (rst)          busy_len <= '0;
      else if (busy[c]) busy_len <= busy_len + 16'd1;
      else              busy_len <= '0;
    end

    a_r3_count_steps: assert property (@(posedge clk) disable iff (rst)
      (enable[c] && !refill[c] && count[c] != '0) |=> count[c] == $past(count[c]) - CNT_W'(1));

    a_r5_single_parks: assert property (@(posedge clk) disable iff (rst)
      (enable[c] && single[c] && !refill[c] && count[c] == '0) |=> count[c] == '0);

    a_r6_expiry_sets: assert property (@(posedge clk) disable iff (rst)
      expire[c] |=> pend[c]);

    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
      (!enable[c] && !refill[c]) |=> ($stable(count[c]) && !$rose(pend[c])));

    a_r9_busy_length: assert property (@(posedge clk) disable iff (rst)
      $fell(busy[c]) |-> busy_len == 16'(CLR_CYCLES));

    a_r11_drop_only_at_end: assert property (@(posedge clk) disable iff (rst)
      $fell(pend[c]) |-> ($past(done[c]) && !$past(expire[c])));
  end
endmodule

bind quad_downtimer qdt_checker #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .CLR_CYCLES(CLR_CYCLES)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .single (ch_single),
  .enable (ch_enable),
  .refill (ch_refill),
  .expire (ch_expire),
  .pend   (ch_pend),
  .busy   (ch_busy),
  .done   (ch_done),
  .count  (ch_count)
);

// File: tb/quad_downtimer_tb.sv
`timescale 1ns/1ps
module quad_downtimer_tb_top;
  localparam logic [5:0] A_STAT = 6'h00, A_MODE = 6'h04, A_REL = 6'h08, A_EN = 6'h10,
                         A_RST = 6'h14, A_CNT = 6'h18, A_ACK = 6'h20, A_MASK = 6'h24;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  quad_downtimer dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write takes the next rising edge
  task automatic wr(input int ch, input logic [5:0] ofs, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {2'(ch), ofs}; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [5:0] ofs, output logic [31:0] v);
    bus_addr = {2'(ch), ofs};
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stop a channel and drain its pending flag
  task automatic quiesce(input int ch);
    wr(ch, A_EN, 0);
    wr(ch, A_ACK, 1);
    idle(5);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp;
    rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    for (int ch = 0; ch < 4; ch++) begin
      rd(ch, A_MODE, v); check("R1 mode", v, 0);
      rd(ch, A_REL, v);  check("R1 reload", v, 0);
      rd(ch, A_EN, v);   check("R1 enable", v, 0);
      rd(ch, A_CNT, v);  check("R1 count", v, 0);
      rd(ch, A_ACK, v);  check("R1 ack", v, 0);
      rd(ch, A_MASK, v); check("R1 mask", v, 1);
    end
    rd(0, A_STAT, v); check("R1 status", v, 0);
    check("R1 irq", {28'd0, irq_o}, 0);

    // R2 readback per bank
    for (int ch = 0; ch < 4; ch++) begin
      wr(ch, A_REL, 32'h89AB_CD00 + ch);
      wr(ch, A_MODE, 1);
      wr(ch, A_MASK, 0);
      rd(ch, A_REL, v);  check("R2 reload", v, 32'h89AB_CD00 + ch);
      rd(ch, A_MODE, v); check("R2 mode", v, 1);
      rd(ch, A_MASK, v); check("R2 mask", v, 0);
      wr(ch, A_MASK, 1);
      rd(ch, A_MASK, v); check("R2 mask", v, 1);
    end

    // R3 R4 R5 R6 sweep: count after k clocks from enable
    for (int ch = 0; ch < 4; ch++)
      for (int md = 0; md < 2; md++)
        for (int L = 1; L <= 5; L++) begin
          quiesce(ch);
          wr(ch, A_REL, L);
          wr(ch, A_MODE, md);
          wr(ch, A_EN, 1);
          for (int k = 0; k <= 2 * L + 2; k++) begin
            if (md == 1) exp = (k >= L) ? 0 : L - k;
            else         exp = L - (k % (L + 1));
            rd(ch, A_CNT, v);
            check(md == 1 ? "R5 one-shot count" : "R4 repeating count", v, exp);
            if (k == L - 1) begin rd(ch, A_ACK, v); check("R6 not yet", v & 1, 0); end
            if (k == L)     begin rd(ch, A_ACK, v); check("R6 pending", v & 1, 1); end
            @(negedge clk);
          end
        end

    // R7 restart with arbitrary data; R8 freeze
    quiesce(1);
    wr(1, A_REL, 20); wr(1, A_MODE, 1); wr(1, A_EN, 1);
    idle(5);
    rd(1, A_CNT, v); check("R3 count", v, 15);
    wr(1, A_RST, 32'hDEAD_BEEF);
    rd(1, A_CNT, v); check("R7 restart", v, 20);
    idle(3);
    wr(1, A_RST, 0);
    rd(1, A_CNT, v); check("R7 restart zero data", v, 20);
    idle(3);
    wr(1, A_EN, 0);
    rd(1, A_CNT, v); check("R8 last step", v, 16);
    idle(20);
    rd(1, A_CNT, v); check("R8 frozen", v, 16);
    rd(1, A_ACK, v); check("R8 no expiry", v, 0);

    // R9 clear handshake length
    quiesce(3);
    wr(3, A_REL, 2); wr(3, A_MODE, 1); wr(3, A_EN, 1);
    idle(4);
    rd(3, A_ACK, v); check("R9 pending before", v, 1);
    wr(3, A_ACK, 1);
    for (int j = 0; j < 4; j++) begin
      rd(3, A_ACK, v); check("R9 busy window", v, 3);
      @(negedge clk);
    end
    rd(3, A_ACK, v); check("R9 cleared", v, 0);
    // R9 writing 0 has no effect
    wr(3, A_RST, 0); idle(3);
    wr(3, A_ACK, 0);
    for (int j = 0; j < 6; j++) begin
      rd(3, A_ACK, v); check("R9 zero write", v, 1);
      @(negedge clk);
    end
    // R10 second request while busy is dropped
    wr(3, A_ACK, 1);
    wr(3, A_ACK, 1);
    rd(3, A_ACK, v); check("R10 busy", v, 3);
    idle(2);
    rd(3, A_ACK, v); check("R10 still busy", v, 3);
    idle(1);
    rd(3, A_ACK, v); check("R10 not extended", v, 0);

    // R11 expiry on the completing edge
    quiesce(2);
    wr(2, A_REL, 5); wr(2, A_MODE, 0); wr(2, A_EN, 1);
    wr(2, A_ACK, 1);
    rd(2, A_ACK, v); check("R11 busy only", v, 2);
    idle(3);
    rd(2, A_ACK, v); check("R11 busy only", v, 2);
    idle(1);
    rd(2, A_ACK, v); check("R11 expiry wins", v, 1);

    // R12 masking
    check("R12 masked", {28'd0, irq_o & 4'b0100}, 0);
    wr(2, A_MASK, 0);
    check("R12 unmasked", {28'd0, irq_o}, 32'h4);
    wr(2, A_MASK, 1);
    check("R12 masked again", {28'd0, irq_o}, 0);

    // R13 status word
    for (int ch = 0; ch < 4; ch++) quiesce(ch);
    rd(0, A_STAT, v); check("R13 status empty", v, 0);
    for (int ch = 1; ch < 4; ch += 2) begin
      wr(ch, A_REL, 1); wr(ch, A_MODE, 1); wr(ch, A_EN, 1);
    end
    idle(2);
    rd(0, A_STAT, v); check("R13 status bits", v, 32'hA);
    rd(1, A_STAT, v); check("R13 other bank", v, 0);

    finish_run();
  end
endmodule